// File: doc/BRIEF.md
# Convolution Accelerator Control Register Bank

This block is the register bank through which a host processor sets up and sequences a small convolutional-network accelerator. The host reaches it over a plain 32-bit word-addressed write/read port. Behind that port sit the settings for the convolution stage, the activation and pooling stage, the image dimensions, and the memory base addresses of the image, weight and bias data. All of these settings are also driven out as ports to the engines.

One control word at offset 0 sequences the work. The host sets a start bit to send a single-cycle start pulse to the data loader, the convolution engine or the activation/pooling engine. Each engine reports completion with a done pulse. The done pulse latches a sticky flag in the control word and raises the shared interrupt. The flag stays set until the host clears it by writing a 1 to it. Values that the engines cannot handle are clamped to a legal setting when they are written. Offsets with no register behind them read as zero.

Top module: `acc_csr_top`

## Requirements
- R1: After reset, every register reads zero except the convolution word and the activation/pooling word. The convolution word reads 0x11 (kernel 1, stride 1). The activation/pooling word reads 0x2 (ReLU, max pooling, 2x2). All start outputs, soft_rst and irq are low.
- R2: At offset 0, a write with bit 1 (loader), bit 2 (convolution) or bit 4 (activation/pooling) set, and bit 0 clear, drives the matching start output high for exactly the one cycle after the write. During that cycle the bit reads back as 1, and in the next cycle it reads 0.
- R3: A conv_done pulse sets control bit 3, and a pool_done pulse sets control bit 5. Each bit stays set with no further pulse.
- R4: Writing 1 to control bit 3 or bit 5 clears that bit. Writing 0 to it leaves it unchanged.
- R5: If a done pulse arrives in the same cycle as a write that clears its bit, the bit ends up set.
- R6: irq is high whenever bit 3 or bit 5 is set. It falls in the cycle after the write that clears the last set done bit.
- R7: Writing 1 to control bit 0 drives soft_rst high for one cycle and clears both done bits. Any start bits in that same write are ignored. During the pulse cycle, bit 0 reads back as 1.
- R8: At offset 1, bits [2:0] hold the kernel size (1 to 3). A written 0 is stored as 1, and a written value above 3 is stored as 3. The stored value drives cfg_kernel.
- R9: At offset 1, bits [5:4] hold the stride. A written 0 is stored as 1, and a written 3 is stored as 2. The stored value drives cfg_stride.
- R10: At offset 2, bit 0 selects leaky ReLU (0 selects ReLU). Bits [2:1] select pooling: 0 is min, 1 is max, 2 is average, and a written 3 is stored as 2. Bit 3 selects 3x3 pooling (0 selects 2x2).
- R11: Offsets 3 and 4 hold the image width and height in their low 16 bits, and their upper bits read zero. Offsets 5, 6, 7 and 8 hold the full 32-bit image size, image base, weight base and bias base.
- R12: Offsets 9 to 15 read zero, and writes to them change no register.
- R13: Every configuration output port equals the field that was last stored at its offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Host write strobe |
| bus_addr | input | ADDR_W | Word offset |
| bus_wdata | input | DATA_W | Host write data |
| bus_rdata | output | DATA_W | Read data for bus_addr (combinational) |
| soft_rst | output | 1 | One-cycle accelerator soft reset pulse |
| start_load | output | 1 | One-cycle loader start pulse |
| start_conv | output | 1 | One-cycle convolution start pulse |
| start_pool | output | 1 | One-cycle activation/pooling start pulse |
| conv_done | input | 1 | Convolution completion pulse |
| pool_done | input | 1 | Activation/pooling completion pulse |
| irq | output | 1 | Interrupt, high while a done flag is set |
| cfg_kernel | output | 2 | Kernel edge size 1..3 |
| cfg_stride | output | 2 | Stride 1 or 2 |
| cfg_act_leaky | output | 1 | Leaky ReLU select |
| cfg_pool_kind | output | 2 | Pooling kind: 0 min, 1 max, 2 average |
| cfg_pool_3x3 | output | 1 | 3x3 pooling select |
| img_width | output | DIM_W | Image width |
| img_height | output | DIM_W | Image height |
| img_size | output | DATA_W | Image size |
| img_base | output | DATA_W | Image base address |
| wgt_base | output | DATA_W | Weight base address |
| bias_base | output | DATA_W | Bias base address |

## Verification
The collision that matters is an engine's done pulse landing in the same cycle as the host's write-1-to-clear of that engine's flag. A lost completion here would hang the host's software. The bench drives pool_done and a clearing write to bit 5 on the same clock edge, then reads the control word and irq and expects the flag to remain set. A second overlap is a soft reset written together with start bits. The bench checks that no start output rises while soft_rst pulses.

// File: rtl/acc_csr_pkg.sv
package acc_csr_pkg;
  localparam int OFS_CTRL      = 0;
  localparam int OFS_CONV      = 1;
  localparam int OFS_APOOL     = 2;
  localparam int OFS_IMG_W     = 3;
  localparam int OFS_IMG_H     = 4;
  localparam int OFS_WIDE0     = 5;
  localparam int N_WIDE        = 4;
  localparam int N_MAPPED      = OFS_WIDE0 + N_WIDE;

  localparam int CB_SRST       = 0;
  localparam int CB_LOAD       = 1;
  localparam int CB_CONV       = 2;
  localparam int CB_CONV_DONE  = 3;
  localparam int CB_POOL       = 4;
  localparam int CB_POOL_DONE  = 5;

  typedef enum logic [1:0] {POOL_MIN = 2'd0, POOL_MAX = 2'd1, POOL_AVG = 2'd2} pool_kind_e;

  function automatic logic [1:0] fit_kernel(input logic [2:0] v);
    if (v == 3'd0)      return 2'd1;
    else if (v > 3'd3)  return 2'd3;
    else                return v[1:0];
  endfunction

  function automatic logic [1:0] fit_stride(input logic [1:0] v);
    if (v == 2'd0)      return 2'd1;
    else if (v == 2'd3) return 2'd2;
    else                return v;
  endfunction

  function automatic logic [1:0] fit_pool(input logic [1:0] v);
    if (v == 2'd3) return POOL_AVG;
    else           return v;
  endfunction
endpackage

// File: rtl/acc_ctrl_word.sv
module acc_ctrl_word
  import acc_csr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_we,
  input  logic [DATA_W-1:0] wdata,
  input  logic [1:0]        eng_done,
  output logic              srst_o,
  output logic [2:0]        start_o,
  output logic [1:0]        done_o,
  output logic [DATA_W-1:0] ctrl_rd
);
  localparam int N_START = 3;
  localparam int N_DONE  = 2;
  localparam int START_POS [N_START] = '{CB_LOAD, CB_CONV, CB_POOL};
  localparam int DONE_POS  [N_DONE]  = '{CB_CONV_DONE, CB_POOL_DONE};

  logic               srst_q, srst_d;
  logic [N_START-1:0] start_q, start_d;
  logic [N_DONE-1:0]  done_q, done_d;
  logic               srst_req;

  assign srst_req = ctrl_we & wdata[CB_SRST];

  always_comb begin
    srst_d = srst_req;
    for (int i = 0; i < N_START; i++)
      start_d[i] = ctrl_we & wdata[START_POS[i]] & ~srst_req;
  end

  // done flags: set by engine pulse (priority), cleared by W1C or soft reset
  for (genvar j = 0; j < N_DONE; j++) begin : g_done
    logic clr;
    assign clr = srst_req | (ctrl_we & wdata[DONE_POS[j]]);
    assign done_d[j] = eng_done[j] | (done_q[j] & ~clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      srst_q  <= 1'b0;
      start_q <= '0;
      done_q  <= '0;
    end else begin
      srst_q  <= srst_d;
      start_q <= start_d;
      done_q  <= done_d;
    end
  end

  always_comb begin
    ctrl_rd          = '0;
    ctrl_rd[CB_SRST] = srst_q;
    for (int i = 0; i < N_START; i++) ctrl_rd[START_POS[i]] = start_q[i];
    for (int j = 0; j < N_DONE; j++)  ctrl_rd[DONE_POS[j]]  = done_q[j];
  end

  assign srst_o  = srst_q;
  assign start_o = start_q;
  assign done_o  = done_q;
endmodule

// File: rtl/acc_cfg_regs.sv
module acc_cfg_regs
  import acc_csr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4,
  parameter int DIM_W  = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          we,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [DATA_W-1:0]             wdata,
  output logic [1:0]                    kernel,
  output logic [1:0]                    stride,
  output logic                          act_leaky,
  output logic [1:0]                    pool_kind,
  output logic                          pool_3x3,
  output logic [1:0][DIM_W-1:0]         dims,
  output logic [N_WIDE-1:0][DATA_W-1:0] wide
);
  logic en_conv, en_apool;
  logic [1:0] kernel_d, stride_d, pool_kind_d;

  assign en_conv  = we && (addr == ADDR_W'(OFS_CONV));
  assign en_apool = we && (addr == ADDR_W'(OFS_APOOL));

  always_comb begin
    kernel_d    = fit_kernel(wdata[2:0]);
    stride_d    = fit_stride(wdata[5:4]);
    pool_kind_d = fit_pool(wdata[2:1]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kernel <= 2'd1;
      stride <= 2'd1;
    end else if (en_conv) begin
      kernel <= kernel_d;
      stride <= stride_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_leaky <= 1'b0;
      pool_kind <= POOL_MAX;
      pool_3x3  <= 1'b0;
    end else if (en_apool) begin
      act_leaky <= wdata[0];
      pool_kind <= pool_kind_d;
      pool_3x3  <= wdata[3];
    end
  end

  for (genvar d = 0; d < 2; d++) begin : g_dim
    logic en;
    assign en = we && (addr == ADDR_W'(OFS_IMG_W + d));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  dims[d] <= '0;
      else if (en) dims[d] <= wdata[DIM_W-1:0];
    end
  end

  for (genvar w = 0; w < N_WIDE; w++) begin : g_wide
    logic en;
    assign en = we && (addr == ADDR_W'(OFS_WIDE0 + w));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  wide[w] <= '0;
      else if (en) wide[w] <= wdata;
    end
  end
endmodule

// File: rtl/acc_rd_mux.sv
module acc_rd_mux
  import acc_csr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4,
  parameter int DIM_W  = 16
) (
  input  logic [ADDR_W-1:0]             addr,
  input  logic [DATA_W-1:0]             ctrl_rd,
  input  logic [1:0]                    kernel,
  input  logic [1:0]                    stride,
  input  logic                          act_leaky,
  input  logic [1:0]                    pool_kind,
  input  logic                          pool_3x3,
  input  logic [1:0][DIM_W-1:0]         dims,
  input  logic [N_WIDE-1:0][DATA_W-1:0] wide,
  output logic [DATA_W-1:0]             rdata
);
  always_comb begin
    rdata = '0;
    if (addr == ADDR_W'(OFS_CTRL)) begin
      rdata = ctrl_rd;
    end else if (addr == ADDR_W'(OFS_CONV)) begin
      rdata[1:0] = kernel;
      rdata[5:4] = stride;
    end else if (addr == ADDR_W'(OFS_APOOL)) begin
      rdata[0]   = act_leaky;
      rdata[2:1] = pool_kind;
      rdata[3]   = pool_3x3;
    end else begin
      for (int d = 0; d < 2; d++)
        if (addr == ADDR_W'(OFS_IMG_W + d)) rdata[DIM_W-1:0] = dims[d];
      for (int w = 0; w < N_WIDE; w++)
        if (addr == ADDR_W'(OFS_WIDE0 + w)) rdata = wide[w];
    end
  end
endmodule

// File: rtl/acc_csr_top.sv
module acc_csr_top
  import acc_csr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4,
  parameter int DIM_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              soft_rst,
  output logic              start_load,
  output logic              start_conv,
  output logic              start_pool,
  input  logic              conv_done,
  input  logic              pool_done,
  output logic              irq,
  output logic [1:0]        cfg_kernel,
  output logic [1:0]        cfg_stride,
  output logic              cfg_act_leaky,
  output logic [1:0]        cfg_pool_kind,
  output logic              cfg_pool_3x3,
  output logic [DIM_W-1:0]  img_width,
  output logic [DIM_W-1:0]  img_height,
  output logic [DATA_W-1:0] img_size,
  output logic [DATA_W-1:0] img_base,
  output logic [DATA_W-1:0] wgt_base,
  output logic [DATA_W-1:0] bias_base
);
  logic                          ctrl_we;
  logic [2:0]                    start_vec;
  logic [1:0]                    done_vec;
  logic [DATA_W-1:0]             ctrl_rd;
  logic [1:0][DIM_W-1:0]         dims;
  logic [N_WIDE-1:0][DATA_W-1:0] wide;

  assign ctrl_we = bus_we && (bus_addr == ADDR_W'(OFS_CTRL));

  acc_ctrl_word #(.DATA_W(DATA_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctrl_we  (ctrl_we),
    .wdata    (bus_wdata),
    .eng_done ({pool_done, conv_done}),
    .srst_o   (soft_rst),
    .start_o  (start_vec),
    .done_o   (done_vec),
    .ctrl_rd  (ctrl_rd)
  );

  acc_cfg_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .DIM_W(DIM_W)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .we        (bus_we),
    .addr      (bus_addr),
    .wdata     (bus_wdata),
    .kernel    (cfg_kernel),
    .stride    (cfg_stride),
    .act_leaky (cfg_act_leaky),
    .pool_kind (cfg_pool_kind),
    .pool_3x3  (cfg_pool_3x3),
    .dims      (dims),
    .wide      (wide)
  );

  acc_rd_mux #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .DIM_W(DIM_W)) u_rd (
    .addr      (bus_addr),
    .ctrl_rd   (ctrl_rd),
    .kernel    (cfg_kernel),
    .stride    (cfg_stride),
    .act_leaky (cfg_act_leaky),
    .pool_kind (cfg_pool_kind),
    .pool_3x3  (cfg_pool_3x3),
    .dims      (dims),
    .wide      (wide),
    .rdata     (bus_rdata)
  );

  assign start_load = start_vec[0];
  assign start_conv = start_vec[1];
  assign start_pool = start_vec[2];
  assign irq        = |done_vec;
  assign img_width  = dims[0];
  assign img_height = dims[1];
  assign img_size   = wide[0];
  assign img_base   = wide[1];
  assign wgt_base   = wide[2];
  assign bias_base  = wide[3];
endmodule

// File: rtl/acc_csr_checker.sv
module acc_csr_checker #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              soft_rst,
  input logic              start_load,
  input logic              start_conv,
  input logic              start_pool,
  input logic              conv_done,
  input logic              pool_done,
  input logic              irq,
  input logic [1:0]        cfg_kernel,
  input logic [1:0]        cfg_stride
);
  logic ctrl_wr;
  assign ctrl_wr = bus_we && (bus_addr == '0);

  a_r2_conv_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (start_conv && !(ctrl_wr && bus_wdata[2])) |=> !start_conv);

  a_r2_load_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (start_load && !(ctrl_wr && bus_wdata[1])) |=> !start_load);

  a_r2_pool_caused_by_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(start_pool) |-> $past(ctrl_wr && bus_wdata[4] && !bus_wdata[0]));

  a_r3_conv_done_irq: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |=> irq);

  a_r3_pool_done_irq: assert property (@(posedge clk) disable iff (!rst_n)
    pool_done |=> irq);

  a_r6_irq_falls_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(ctrl_wr));

  a_r7_srst_blocks_starts: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |-> !(start_load || start_conv || start_pool));

  a_r8_kernel_legal: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_kernel != 2'd0);

  a_r9_stride_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_stride == 2'd1) || (cfg_stride == 2'd2));

  a_r12_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr >= ADDR_W'(9)) |-> (bus_rdata == '0));
endmodule

bind acc_csr_top acc_csr_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_we     (bus_we),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .soft_rst   (soft_rst),
  .start_load (start_load),
  .start_conv (start_conv),
  .start_pool (start_pool),
  .conv_done  (conv_done),
  .pool_done  (pool_done),
  .irq        (irq),
  .cfg_kernel (cfg_kernel),
  .cfg_stride (cfg_stride)
);

// File: tb/acc_csr_top_tb.sv
module acc_csr_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 4;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          bus_we;
  logic [AW-1:0] bus_addr;
  logic [31:0]   bus_wdata, bus_rdata;
  logic          soft_rst, start_load, start_conv, start_pool;
  logic          conv_done, pool_done, irq;
  logic [1:0]    cfg_kernel, cfg_stride, cfg_pool_kind;
  logic          cfg_act_leaky, cfg_pool_3x3;
  logic [DW-1:0] img_width, img_height;
  logic [31:0]   img_size, img_base, wgt_base, bias_base;

  int n_checks = 0;
  int n_errors = 0;
  logic [31:0] model [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  acc_csr_top #(.DATA_W(32), .ADDR_W(AW), .DIM_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .soft_rst(soft_rst),
    .start_load(start_load), .start_conv(start_conv), .start_pool(start_pool),
    .conv_done(conv_done), .pool_done(pool_done), .irq(irq),
    .cfg_kernel(cfg_kernel), .cfg_stride(cfg_stride), .cfg_act_leaky(cfg_act_leaky),
    .cfg_pool_kind(cfg_pool_kind), .cfg_pool_3x3(cfg_pool_3x3),
    .img_width(img_width), .img_height(img_height), .img_size(img_size),
    .img_base(img_base), .wgt_base(wgt_base), .bias_base(bias_base)
  );

  function automatic logic [31:0] expect_word(input int ofs, input logic [31:0] d);
    logic [31:0] k, s, p;
    case (ofs)
      1: begin
        k = {29'd0, d[2:0]};
        if (k == 0) k = 1; else if (k > 3) k = 3;
        s = {30'd0, d[5:4]};
        if (s == 0) s = 1; else if (s == 3) s = 2;
        return (s << 4) | k;
      end
      2: begin
        p = {30'd0, d[2:1]};
        if (p == 3) p = 2;
        return {31'd0, d[0]} | (p << 1) | ({31'd0, d[3]} << 3);
      end
      3, 4: return d & 32'h0000_FFFF;
      5, 6, 7, 8: return d;
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tag_of(input int ofs);
    case (ofs)
      1: return "R8 R9";
      2: return "R10";
      3, 4, 5, 6, 7, 8: return "R11";
      default: return "R12";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input int ofs, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = AW'(ofs); bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic bus_read(input int ofs, output logic [31:0] d);
    bus_addr = AW'(ofs);
    #1;
    d = bus_rdata;
  endtask

  task automatic pulse_done(input logic c, input logic p);
    @(negedge clk);
    conv_done = c; pool_done = p;
    @(negedge clk);
    conv_done = 1'b0; pool_done = 1'b0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [31:0] rd;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    conv_done = 1'b0; pool_done = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 16; a++) begin
      model[a] = (a == 1) ? 32'h11 : (a == 2) ? 32'h2 : 32'h0;
      bus_read(a, rd);
      check("R1 reset readback", rd, model[a]);
    end
    check("R1 reset outputs", {28'd0, soft_rst, start_load, start_conv, start_pool}, 32'd0);
    check("R1 reset irq", {31'd0, irq}, 32'd0);

    // R2 start pulses for each engine
    for (int e = 0; e < 3; e++) begin
      logic [31:0] bitv, outs;
      bitv = (e == 0) ? 32'h2 : (e == 1) ? 32'h4 : 32'h10;
      bus_write(0, bitv);
      outs = {29'd0, start_load, start_conv, start_pool};
      check("R2 start pulse high", outs, (e == 0) ? 32'h4 : (e == 1) ? 32'h2 : 32'h1);
      bus_read(0, rd);
      check("R2 start bit readback", rd, bitv);
      @(negedge clk);
      check("R2 start self-clear", {29'd0, start_load, start_conv, start_pool}, 32'd0);
      bus_read(0, rd);
      check("R2 start bit cleared", rd, 32'd0);
    end

    // R3 / R6 convolution done latches and raises irq
    pulse_done(1'b1, 1'b0);
    bus_read(0, rd);
    check("R3 conv done bit", rd, 32'h8);
    check("R6 irq on done", {31'd0, irq}, 32'd1);
    repeat (4) @(negedge clk);
    bus_read(0, rd);
    check("R3 conv done sticky", rd, 32'h8);
    // R4 writing 0 keeps it
    bus_write(0, 32'h0);
    bus_read(0, rd);
    check("R4 write 0 keeps done", rd, 32'h8);
    bus_write(0, 32'h8);
    bus_read(0, rd);
    check("R4 W1C conv done", rd, 32'h0);
    check("R6 irq falls after clear", {31'd0, irq}, 32'd0);

    // R5 collision: pool done together with its clearing write
    pulse_done(1'b0, 1'b1);
    bus_read(0, rd);
    check("R3 pool done bit", rd, 32'h20);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = '0; bus_wdata = 32'h20; pool_done = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0; pool_done = 1'b0;
    bus_read(0, rd);
    check("R5 set wins over clear", rd, 32'h20);
    check("R5 irq held", {31'd0, irq}, 32'd1);
    bus_write(0, 32'h20);
    bus_read(0, rd);
    check("R4 W1C pool done", rd, 32'h0);

    // R7 soft reset clears done bits and suppresses starts
    pulse_done(1'b1, 1'b1);
    bus_read(0, rd);
    check("R3 both done bits", rd, 32'h28);
    bus_write(0, 32'h17);
    check("R7 soft_rst pulse", {31'd0, soft_rst}, 32'd1);
    check("R7 starts suppressed", {29'd0, start_load, start_conv, start_pool}, 32'd0);
    bus_read(0, rd);
    check("R7 readback during pulse", rd, 32'h1);
    @(negedge clk);
    check("R7 soft_rst one cycle", {31'd0, soft_rst}, 32'd0);
    check("R7 irq cleared", {31'd0, irq}, 32'd0);

    // R8 R9 R10 R13 directed clamp corners
    bus_write(1, 32'h0);
    bus_read(1, rd);
    check("R8 R9 zero clamps", rd, 32'h11);
    bus_write(1, 32'h37);
    bus_read(1, rd);
    check("R8 R9 high clamps", rd, 32'h23);
    check("R13 cfg_kernel port", {30'd0, cfg_kernel}, 32'd3);
    check("R13 cfg_stride port", {30'd0, cfg_stride}, 32'd2);
    bus_write(1, 32'h22);
    bus_read(1, rd);
    check("R8 R9 legal kept", rd, 32'h22);
    bus_write(2, 32'hF);
    bus_read(2, rd);
    check("R10 pool kind 3 clamps", rd, 32'hD);
    check("R13 pool ports", {28'd0, cfg_pool_3x3, cfg_pool_kind, cfg_act_leaky}, 32'hD);
    model[1] = 32'h22; model[2] = 32'hD;

    // Random config traffic over offsets 1..15 (R8-R12 by offset)
    for (int it = 0; it < 300; it++) begin
      int ofs;
      logic [31:0] d;
      ofs = 1 + int'($urandom % 15);
      d = $urandom;
      if (it % 7 == 0) d[5:4] = 2'd3;
      if (it % 5 == 0) d[2:0] = 3'd0;
      bus_write(ofs, d);
      if (ofs < 9) model[ofs] = expect_word(ofs, d);
      for (int a = 1; a < 16; a++) begin
        bus_read(a, rd);
        check(tag_of(a), rd, model[a]);
      end
    end

    // R13 ports against the model
    check("R13 img_width", {16'd0, img_width}, model[3]);
    check("R13 img_height", {16'd0, img_height}, model[4]);
    check("R13 img_size", img_size, model[5]);
    check("R13 img_base", img_base, model[6]);
    check("R13 wgt_base", wgt_base, model[7]);
    check("R13 bias_base", bias_base, model[8]);
    check("R13 conv ports", {26'd0, cfg_stride, 2'd0, cfg_kernel}, model[1]);

    finish_run();
  end
endmodule